// File: doc/BRIEF.md
# Fault Protection and Interrupt Controller

This block collects nine fault and event inputs from the surrounding speaker amplifier, synchronises them, and records each rising edge in a sticky status bit. Two mask registers decide which recorded events pull a shared active-low interrupt line. Software finds the cause by reading the two status registers, and each read clears the register it reads.

The block also drives a protective safe-mode flag. Safe mode comes on by itself whenever an overtemperature error or an amplifier short is present. Once latched, a cause stays latched after its condition goes away. Software releases each cause on its own release bit in a control register by writing 0, then 1, then 0 to that bit. The release takes effect only if the condition was never seen from the last 0 write before the 1 through the final 0 write. Safe mode stays on while any cause remains latched. Registers are accessed through a plain address, write-data, read-data and strobe port. Read data is combinational from the address, and the clear-on-read side effect happens at the clock edge where the read strobe is high.

Top module: `fpi_ctrl`

## Requirements
- R1: After reset, both status registers read 0x00, the mask registers at 0x12 and 0x13 read 0x1F and 0xE1, irq_n is 1 and safe_mode is 0.
- R2: Mask register 0x12 holds the masks for overtemperature error (bit 0), overtemperature warning (bit 1), amplifier short (bit 2), master clock error (bit 3) and serial-port clock error (bit 4). Mask register 0x13 holds the masks for power-down-done (bit 0), supply monitor overflow (bit 5), current monitor overflow (bit 6) and voltage monitor overflow (bit 7). A 1 masks the source. The other bits read 0 and ignore writes.
- R3: A rising edge on a fault input sets its status bit three clock edges later. Status register 0x10 uses the bit positions of mask register 0x12, and status register 0x11 uses those of 0x13. Once set, a bit stays set until it is read.
- R4: A read of 0x10 or 0x11 returns the bits and clears them at the same edge. A new edge that lands on that same clock edge sets its bit anyway.
- R5: irq_n is 0 exactly while some status bit is 1 and its mask bit is 0.
- R6: safe_mode is 1 from the third clock edge after an overtemperature error or amplifier short input goes high, and it stays 1 after the input falls.
- R7: Control register 0x14 holds the overtemperature release bit (bit 0) and the short release bit (bit 1), and it reads them back. Writing 0, then 1, then 0 to a release bit clears that cause once its condition is gone. Writes that do not complete this order release nothing.
- R8: safe_mode stays 1 after a completed release while the other cause is still latched.
- R9: If a cause's condition is seen from the last 0 write through the final 0 write, the release is cancelled. A fresh rising edge also sets the status bit again, and if the source is unmasked irq_n goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clears status on read |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| ot_err_i | input | 1 | Overtemperature error (asynchronous) |
| ot_warn_i | input | 1 | Overtemperature warning (asynchronous) |
| amp_short_i | input | 1 | Amplifier short (asynchronous) |
| mclk_err_i | input | 1 | Master clock error (asynchronous) |
| sclk_err_i | input | 1 | Serial-port clock error (asynchronous) |
| vmon_ovf_i | input | 1 | Voltage monitor overflow (asynchronous) |
| imon_ovf_i | input | 1 | Current monitor overflow (asynchronous) |
| smon_ovf_i | input | 1 | Supply monitor overflow (asynchronous) |
| pdn_done_i | input | 1 | Power-down complete (asynchronous) |
| irq_n | output | 1 | Active-low interrupt |
| safe_mode | output | 1 | Protection active |

## Verification
A lost or spurious sticky bit shows up at the next status read, and through irq_n on the same cycle if the source is unmasked. A release sequencer in the wrong state shows up only at the final 0 write of a sequence: safe_mode either drops when it should hold, or holds when it should drop. The bench therefore checks safe_mode right after every control write in the sequence tests. A cancel flag that does not clear leaves safe_mode stuck on through a later clean sequence, so the bench also runs a clean sequence after a cancelled one.

// File: rtl/fpi_pkg.sv
`timescale 1ns/1ps
package fpi_pkg;
  localparam int NUM_SRC   = 9;
  localparam int IDX_OTE   = 0;
  localparam int IDX_OTW   = 1;
  localparam int IDX_SHORT = 2;
  localparam int IDX_MCLK  = 3;
  localparam int IDX_SCLK  = 4;
  localparam int IDX_VMON  = 5;
  localparam int IDX_IMON  = 6;
  localparam int IDX_SMON  = 7;
  localparam int IDX_PDN   = 8;

  localparam logic [7:0] A_STS1 = 8'h10;
  localparam logic [7:0] A_STS2 = 8'h11;
  localparam logic [7:0] A_MSK1 = 8'h12;
  localparam logic [7:0] A_MSK2 = 8'h13;
  localparam logic [7:0] A_CTRL = 8'h14;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_SAW0, SEQ_SAW1} seq_t;
endpackage

// File: rtl/fpi_sync_rise.sv
`timescale 1ns/1ps
module fpi_sync_rise #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      prev_q <= '0;
    end else begin
      chain[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev_q <= chain[STAGES-1];
    end
  end

  assign lvl_o  = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/fpi_release_seq.sv
`timescale 1ns/1ps
module fpi_release_seq
  import fpi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wbit,
  input  logic cond,
  output logic lock_o
);
  seq_t state_q, state_d;
  logic cancel_q, cancel_d;
  logic release_now;

  always_comb begin
    state_d  = state_q;
    cancel_d = (state_q != SEQ_IDLE) ? (cancel_q | cond) : 1'b0;
    if (wr_stb) begin
      if (!wbit) begin
        state_d  = SEQ_SAW0;
        cancel_d = cond;
      end else if (state_q != SEQ_IDLE) begin
        state_d = SEQ_SAW1;
      end
    end
  end

  assign release_now = wr_stb && !wbit && (state_q == SEQ_SAW1) && !cancel_q && !cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      cancel_q <= 1'b0;
      lock_o   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cancel_q <= cancel_d;
      if (cond)             lock_o <= 1'b1;
      else if (release_now) lock_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fpi_ctrl.sv
`timescale 1ns/1ps
module fpi_ctrl
  import fpi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_REL     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ot_err_i,
  input  logic       ot_warn_i,
  input  logic       amp_short_i,
  input  logic       mclk_err_i,
  input  logic       sclk_err_i,
  input  logic       vmon_ovf_i,
  input  logic       imon_ovf_i,
  input  logic       smon_ovf_i,
  input  logic       pdn_done_i,
  output logic       irq_n,
  output logic       safe_mode
);
  localparam logic [NUM_SRC-1:0] MSK_RST = '1;

  logic [NUM_SRC-1:0] raw, f_lvl, f_rise, sts_q, msk_q, clr;
  logic [NUM_REL-1:0] ctl_q, lock;

  assign raw = {pdn_done_i, smon_ovf_i, imon_ovf_i, vmon_ovf_i,
                sclk_err_i, mclk_err_i, amp_short_i, ot_warn_i, ot_err_i};

  fpi_sync_rise #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .lvl_o(f_lvl), .rise_o(f_rise)
  );

  always_comb begin
    clr = '0;
    if (reg_rd && reg_addr == A_STS1) clr[IDX_SCLK:IDX_OTE] = '1;
    if (reg_rd && reg_addr == A_STS2) clr[IDX_PDN:IDX_VMON] = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      msk_q <= MSK_RST;
      ctl_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr) | f_rise;
      if (reg_wr && reg_addr == A_MSK1) msk_q[IDX_SCLK:IDX_OTE] <= reg_wdata[4:0];
      if (reg_wr && reg_addr == A_MSK2) begin
        msk_q[IDX_VMON] <= reg_wdata[7];
        msk_q[IDX_IMON] <= reg_wdata[6];
        msk_q[IDX_SMON] <= reg_wdata[5];
        msk_q[IDX_PDN]  <= reg_wdata[0];
      end
      if (reg_wr && reg_addr == A_CTRL) ctl_q <= reg_wdata[NUM_REL-1:0];
    end
  end

  for (genvar g = 0; g < NUM_REL; g++) begin : g_rel
    localparam int CIDX = (g == 0) ? IDX_OTE : IDX_SHORT;
    fpi_release_seq u_seq (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(reg_wr && reg_addr == A_CTRL),
      .wbit(reg_wdata[g]),
      .cond(f_lvl[CIDX]),
      .lock_o(lock[g])
    );
  end

  always_comb begin
    case (reg_addr)
      A_STS1:  reg_rdata = {3'b000, sts_q[IDX_SCLK:IDX_OTE]};
      A_STS2:  reg_rdata = {sts_q[IDX_VMON], sts_q[IDX_IMON], sts_q[IDX_SMON], 4'b0000, sts_q[IDX_PDN]};
      A_MSK1:  reg_rdata = {3'b000, msk_q[IDX_SCLK:IDX_OTE]};
      A_MSK2:  reg_rdata = {msk_q[IDX_VMON], msk_q[IDX_IMON], msk_q[IDX_SMON], 4'b0000, msk_q[IDX_PDN]};
      A_CTRL:  reg_rdata = {{(8-NUM_REL){1'b0}}, ctl_q};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq_n     = ~|(sts_q & ~msk_q);
  assign safe_mode = |lock;
endmodule

// File: rtl/fpi_ctrl_chk.sv
`timescale 1ns/1ps
module fpi_ctrl_chk
  import fpi_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [7:0]         reg_addr,
  input logic               irq_n,
  input logic               safe_mode,
  input logic [NUM_SRC-1:0] lvl,
  input logic [NUM_SRC-1:0] sts
);
  a_r6_safe_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[IDX_OTE] || lvl[IDX_SHORT]) |=> safe_mode);

  a_r7_drop_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(safe_mode) |-> $past(reg_wr && reg_addr == A_CTRL));

  a_r8_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(safe_mode) |-> $past(!lvl[IDX_OTE] && !lvl[IDX_SHORT]));

  a_r5_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (sts != '0));

  a_r3_sticky_bits: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd) |-> (($past(sts) & ~sts) == '0));
endmodule

bind fpi_ctrl fpi_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .irq_n(irq_n), .safe_mode(safe_mode),
  .lvl(f_lvl), .sts(sts_q)
);

// File: tb/sim_fpi_ctrl.sv
`timescale 1ns/1ps
module sim_fpi_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
  logic [8:0] flt = '0;
  logic irq_n, safe_mode;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpi_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ot_err_i(flt[0]), .ot_warn_i(flt[1]), .amp_short_i(flt[2]),
    .mclk_err_i(flt[3]), .sclk_err_i(flt[4]), .vmon_ovf_i(flt[5]),
    .imon_ovf_i(flt[6]), .smon_ovf_i(flt[7]), .pdn_done_i(flt[8]),
    .irq_n(irq_n), .safe_mode(safe_mode)
  );

  typedef struct packed {
    logic [7:0] m1; logic [7:0] m2; logic [8:0] f;
    logic [7:0] s1; logic [7:0] s2; logic irq;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h1F, 8'hE1, 9'h002, 8'h02, 8'h00, 1'b1},
    '{8'h1D, 8'hE1, 9'h002, 8'h02, 8'h00, 1'b0},
    '{8'h00, 8'h00, 9'h100, 8'h00, 8'h01, 1'b0},
    '{8'h1F, 8'h61, 9'h020, 8'h00, 8'h80, 1'b0},
    '{8'h0F, 8'hE1, 9'h018, 8'h18, 8'h00, 1'b0},
    '{8'hFF, 8'hFF, 9'h0C0, 8'h00, 8'h60, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 safe_mode", {7'd0, safe_mode}, 8'h00);
    rd(8'h12, d); chk("R1 mask1", d, 8'h1F);
    rd(8'h13, d); chk("R1 mask2", d, 8'hE1);
    rd(8'h10, d); chk("R1 status1", d, 8'h00);
    rd(8'h11, d); chk("R1 status2", d, 8'h00);

    // vector table: R2 masks, R3 status layout, R4 clear, R5 irq
    for (int i = 0; i < 6; i++) begin
      wr(8'h12, VECS[i].m1);
      wr(8'h13, VECS[i].m2);
      rd(8'h12, d); chk("R2 mask1 readback", d, VECS[i].m1 & 8'h1F);
      rd(8'h13, d); chk("R2 mask2 readback", d, VECS[i].m2 & 8'hE1);
      @(negedge clk); flt = VECS[i].f;
      settle();
      flt = '0;
      settle();
      chk("R5 irq_n with event", {7'd0, irq_n}, {7'd0, VECS[i].irq});
      rd(8'h10, d); chk("R3 status1", d, VECS[i].s1);
      rd(8'h11, d); chk("R3 status2", d, VECS[i].s2);
      rd(8'h10, d); chk("R4 status1 cleared", d, 8'h00);
      rd(8'h11, d); chk("R4 status2 cleared", d, 8'h00);
      chk("R5 irq_n after clear", {7'd0, irq_n}, 8'h01);
    end
    wr(8'h12, 8'h1F); wr(8'h13, 8'hE1);

    // R4 set lands on the clearing read edge
    @(negedge clk); flt[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 8'h10;
    #1 d = reg_rdata; chk("R4 before set", d, 8'h00);
    @(negedge clk); reg_rd = 1'b0;
    rd(8'h10, d); chk("R4 set wins over clear", d, 8'h02);
    flt[1] = 1'b0; settle();
    rd(8'h10, d); chk("R4 cleared after read", d, 8'h00);

    // R7 control readback
    wr(8'h14, 8'hFF);
    rd(8'h14, d); chk("R7 control readback", d, 8'h03);

    // R6 entry and hold
    @(negedge clk); flt[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 not yet", {7'd0, safe_mode}, 8'h00);
    @(negedge clk);
    chk("R6 safe on third edge", {7'd0, safe_mode}, 8'h01);
    flt[0] = 1'b0; settle();
    chk("R6 safe holds", {7'd0, safe_mode}, 8'h01);
    rd(8'h10, d); chk("R6 status ote", d, 8'h01);

    // R7 incomplete orders do not release
    wr(8'h14, 8'h00); wr(8'h14, 8'h00);
    chk("R7 0,0 no release", {7'd0, safe_mode}, 8'h01);
    wr(8'h14, 8'h01);
    chk("R7 0,1 no release", {7'd0, safe_mode}, 8'h01);
    wr(8'h14, 8'h01);
    chk("R7 repeated 1 no release", {7'd0, safe_mode}, 8'h01);
    wr(8'h14, 8'h00);
    chk("R7 0,1,0 releases", {7'd0, safe_mode}, 8'h00);

    // R9 recurrence mid-sequence cancels
    @(negedge clk); flt[0] = 1'b1; settle(); flt[0] = 1'b0; settle();
    rd(8'h10, d);
    wr(8'h14, 8'h00); wr(8'h14, 8'h01);
    flt[0] = 1'b1; settle(); flt[0] = 1'b0; settle();
    wr(8'h12, 8'h1E);
    chk("R9 irq on recurrence", {7'd0, irq_n}, 8'h00);
    wr(8'h14, 8'h00);
    chk("R9 release cancelled", {7'd0, safe_mode}, 8'h01);
    rd(8'h10, d); chk("R9 status set again", d, 8'h01);
    wr(8'h12, 8'h1F);
    wr(8'h14, 8'h01); wr(8'h14, 8'h00);
    chk("R9 clean retry releases", {7'd0, safe_mode}, 8'h00);

    // R8 other cause keeps safe mode
    @(negedge clk); flt[0] = 1'b1; flt[2] = 1'b1; settle();
    flt[0] = 1'b0; settle();
    wr(8'h14, 8'h00); wr(8'h14, 8'h01); wr(8'h14, 8'h00);
    chk("R8 short still active", {7'd0, safe_mode}, 8'h01);
    flt[2] = 1'b0; settle();
    wr(8'h14, 8'h00); wr(8'h14, 8'h02); wr(8'h14, 8'h00);
    chk("R8 both released", {7'd0, safe_mode}, 8'h00);
    rd(8'h10, d); chk("R8 status ote and short", d, 8'h05);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule